// File: doc/BRIEF.md
# Shared-Carry Byte ALU

This block is a byte-wide arithmetic and logic unit whose bitwise functions come from the adder's own per-bit carry terms rather than from a separate gate array. The second operand is inverted when the function needs it. The inverted operand then feeds one row of generate terms (AND) and one row of propagate terms (OR). A half-sum is formed from those two rows as propagate AND NOT generate. The same rows drive a parallel-prefix carry network. AND, OR, XOR, AND-NOT and a pass-through of the first operand are all taken from these rows. A two-way selector picks one logic result, and a final selector chooses between that result and the adder sum.

The opcode map was chosen so that every control line is a one- or two-term function of the four function bits. The result, the carry out, the less-than flag and a write-enable are registered together. A result therefore appears one clock after its operands and function code are applied. Compare functions produce flags but drop the write-enable. Codes outside the map produce an all-zero output.

Top module: `alu8_core`

## Requirements
- R1: While rst_n is low, res, cout, lt and we are all zero.
- R2: The outputs for the operands and function code present at a rising clock edge appear after that edge and hold until the next edge.
- R3: Code 0000 gives sri AND snd; code 0011 gives sri AND NOT snd; both give we=1, cout=0, lt=0.
- R4: Code 0001 gives sri OR snd; code 0010 gives sri XOR snd; both give we=1, cout=0, lt=0.
- R5: Code 1000 returns sri unchanged whatever snd is, with we=1, cout=0, lt=0.
- R6: Code 0111 gives the low 8 bits of sri+snd, with cout the ninth bit, we=1 and lt=0.
- R7: Code 0110 gives sri-snd modulo 256, with cout=1 exactly when sri >= snd unsigned, we=1 and lt=0.
- R8: Code 0100 gives res=sri-snd and cout as in R7, we=0, and lt=1 exactly when sri < snd as unsigned numbers.
- R9: Code 0101 gives res=sri-snd and cout as in R7, we=0, and lt=1 exactly when sri < snd as two's-complement numbers.
- R10: Codes 1001 to 1111 give res=0, cout=0, lt=0 and we=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge captures the result |
| rst_n | input | 1 | Active-low asynchronous reset |
| sri | input | 8 | First operand |
| snd | input | 8 | Second operand, inverted internally when the function needs it |
| func | input | 4 | Function code, bit 3 first |
| res | output | 8 | Registered result |
| cout | output | 1 | Registered adder carry out; zero for non-arithmetic codes |
| lt | output | 1 | Registered less-than flag from a compare code |
| we | output | 1 | Registered write-enable; low for compares and unused codes |

## Verification
The properties assume that sri, snd and func are stable at each rising edge and are free of unknowns once reset is released. They also assume that outputs are only judged from the second edge after reset, because the first edge loads the operands that were present as reset ended. The stimulus changes inputs only on falling edges and keeps them defined throughout. It sweeps all sixteen function codes over the corner operands 00, 01, 7F, 80 and FF, equal pairs and random pairs. This covers signed and unsigned compares on both sides of the sign boundary, carry out of the top bit, and the unused codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        FN_AND  = 4'b0000,
        FN_OR   = 4'b0001,
        FN_XOR  = 4'b0010,
        FN_ANDN = 4'b0011,
        FN_CMPU = 4'b0100,
        FN_CMPS = 4'b0101,
        FN_SUB  = 4'b0110,
        FN_ADD  = 4'b0111,
        FN_SET  = 4'b1000
    } alu_fn_e;

    typedef struct packed {
        logic known;     // code belongs to the map
        logic pass;      // restore sri onto the AND path
        logic neg;       // invert snd before the P/G rows
        logic orx;       // force the OR result on the X path
        logic xsel;      // pick the X path over the AND path
        logic arith;     // take the adder sum
        logic cin;       // adder carry in
        logic cmp_u;     // unsigned compare
        logic cmp_s;     // signed compare
        logic wr;        // result is written back
    } alu_ctrl_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [3:0] func,
    output alu_ctrl_t  ctrl
);
    logic f0, f1, f2, f3;

    always_comb begin
        f0 = func[0];
        f1 = func[1];
        f2 = func[2];
        f3 = func[3];
        ctrl.known = !f3 || (func == FN_SET);
        ctrl.pass  = f3;
        ctrl.neg   = (f0 & f1) ^ f2;
        ctrl.orx   = !(f1 | f2 | f3);
        ctrl.xsel  = f0 ^ f1;
        ctrl.arith = f2;
        ctrl.cin   = f2 & ((f0 & f1) ^ f2);
        ctrl.cmp_u = (func == FN_CMPU);
        ctrl.cmp_s = (func == FN_CMPS);
        ctrl.wr    = ctrl.known && !(ctrl.cmp_u || ctrl.cmp_s);
    end
endmodule

// File: rtl/alu8_pgrow.sv
module alu8_pgrow #(
    parameter int W = 8
) (
    input  logic [W-1:0] sri,
    input  logic [W-1:0] snd,
    input  logic         neg,
    input  logic         pass,
    input  logic         orx,
    input  logic         xsel,
    output logic [W-1:0] gen,
    output logic [W-1:0] prop,
    output logic [W-1:0] half,
    output logic [W-1:0] logic_res
);
    logic [W-1:0] opb;
    logic [W-1:0] and_path;
    logic [W-1:0] x_path;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            always_comb begin
                opb[i]      = snd[i] ^ neg;
                gen[i]      = sri[i] & opb[i];
                prop[i]     = sri[i] | opb[i];
                half[i]     = prop[i] & ~gen[i];
                and_path[i] = gen[i] | (sri[i] & pass);
                x_path[i]   = prop[i] & (~gen[i] | orx);
                logic_res[i] = xsel ? x_path[i] : and_path[i];
            end
        end
    endgenerate
endmodule

// File: rtl/alu8_prefix.sv
module alu8_prefix #(
    parameter int W = 8
) (
    input  logic [W-1:0] gen,
    input  logic [W-1:0] prop,
    input  logic [W-1:0] half,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         c_msb
);
    localparam int LV = (W > 1) ? $clog2(W) : 1;

    logic [LV:0][W-1:0] gl;
    logic [LV:0][W-1:0] pl;
    logic [W:0]         carry;

    always_comb begin
        gl[0]    = gen;
        pl[0]    = prop;
        gl[0][0] = gen[0] | (prop[0] & cin);
    end

    generate
        for (genvar l = 0; l < LV; l++) begin : g_lvl
            localparam int D = 1 << l;
            for (genvar i = 0; i < W; i++) begin : g_col
                if (i >= D) begin : g_mrg
                    always_comb begin
                        gl[l+1][i] = gl[l][i] | (pl[l][i] & gl[l][i-D]);
                        pl[l+1][i] = pl[l][i] & pl[l][i-D];
                    end
                end else begin : g_cpy
                    always_comb begin
                        gl[l+1][i] = gl[l][i];
                        pl[l+1][i] = pl[l][i];
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        carry[0]   = cin;
        carry[W:1] = gl[LV];
        sum        = half ^ carry[W-1:0];
        cout       = carry[W];
        c_msb      = carry[W-1];
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sri,
    input  logic [W-1:0] snd,
    input  logic [3:0]   func,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         lt,
    output logic         we
);
    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] res;
        logic         cout;
        logic         lt;
        logic         we;
    } out_t;

    alu_ctrl_t    ctrl;
    logic [W-1:0] gen, prop, half, logic_res, sum;
    logic         add_co, c_msb;
    out_t         out_d, out_q;

    alu8_decode u_dec (
        .func (func),
        .ctrl (ctrl)
    );

    alu8_pgrow #(.W(W)) u_pg (
        .sri       (sri),
        .snd       (snd),
        .neg       (ctrl.neg),
        .pass      (ctrl.pass),
        .orx       (ctrl.orx),
        .xsel      (ctrl.xsel),
        .gen       (gen),
        .prop      (prop),
        .half      (half),
        .logic_res (logic_res)
    );

    alu8_prefix #(.W(W)) u_add (
        .gen   (gen),
        .prop  (prop),
        .half  (half),
        .cin   (ctrl.cin),
        .sum   (sum),
        .cout  (add_co),
        .c_msb (c_msb)
    );

    always_comb begin
        logic ovf;
        ovf = add_co ^ c_msb;
        out_d = '0;
        if (ctrl.known) begin
            out_d.res  = ctrl.arith ? sum : logic_res;
            out_d.cout = ctrl.arith & add_co;
            out_d.we   = ctrl.wr;
            if (ctrl.cmp_u)
                out_d.lt = ~add_co;
            else if (ctrl.cmp_s)
                out_d.lt = sum[MSB] ^ ovf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign res  = out_q.res;
    assign cout = out_q.cout;
    assign lt   = out_q.lt;
    assign we   = out_q.we;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] sri,
    input logic [W-1:0] snd,
    input logic [3:0]   func,
    input logic [W-1:0] res,
    input logic         cout,
    input logic         lt,
    input logic         we
);
    logic live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            live_q <= 1'b0;
        else
            live_q <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (res == '0 && !cout && !lt && !we));

    // R10
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(func) > 4'd8) |-> (res == '0 && !cout && !lt && !we));

    // R8
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ($past(func) == 4'd4 || $past(func) == 4'd5)) |-> !we);

    // R5
    set_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(func) == 4'd8) |-> (res == $past(sri) && we && !cout && !lt));

    // R4
    logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(func) < 4'd4) |-> (we && !cout && !lt));

    // R6
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(func) == 4'd7) |->
        ({cout, res} == ({1'b0, $past(sri)} + {1'b0, $past(snd)})));
endmodule

bind alu8_core alu8_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sri   (sri),
    .snd   (snd),
    .func  (func),
    .res   (res),
    .cout  (cout),
    .lt    (lt),
    .we    (we)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sri = '0;
    logic [7:0] snd = '0;
    logic [3:0] func = '0;
    logic [7:0] res;
    logic       cout, lt, we;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int         stamp;
        logic [3:0] fn;
        logic [7:0] a, b;
        logic [7:0] res;
        logic       cout, lt, we;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst_n(rst_n), .sri(sri), .snd(snd), .func(func),
        .res(res), .cout(cout), .lt(lt), .we(we)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic string req_of(input logic [3:0] fn);
        case (fn)
            4'd0, 4'd3: return "R3";
            4'd1, 4'd2: return "R4";
            4'd8:       return "R5";
            4'd7:       return "R6";
            4'd6:       return "R7";
            4'd4:       return "R8";
            4'd5:       return "R9";
            default:    return "R10";
        endcase
    endfunction

    function automatic item_t model(input logic [3:0] fn, input logic [7:0] a, input logic [7:0] b);
        item_t e;
        logic [8:0] s;
        e.fn = fn; e.a = a; e.b = b;
        e.res = '0; e.cout = 0; e.lt = 0; e.we = 0;
        case (fn)
            4'd0: begin e.res = a & b;  e.we = 1; end
            4'd1: begin e.res = a | b;  e.we = 1; end
            4'd2: begin e.res = a ^ b;  e.we = 1; end
            4'd3: begin e.res = a & ~b; e.we = 1; end
            4'd8: begin e.res = a;      e.we = 1; end
            4'd7: begin s = {1'b0, a} + {1'b0, b}; e.res = s[7:0]; e.cout = s[8]; e.we = 1; end
            4'd6, 4'd4, 4'd5: begin
                e.res  = a - b;
                e.cout = (a >= b);
                e.we   = (fn == 4'd6);
                if (fn == 4'd4) e.lt = (a < b);
                if (fn == 4'd5) e.lt = ($signed(a) < $signed(b));
            end
            default: ;
        endcase
        return e;
    endfunction

    task automatic drive(input logic [3:0] fn, input logic [7:0] a, input logic [7:0] b);
        item_t e;
        @(negedge clk);
        sri = a; snd = b; func = fn;
        e = model(fn, a, b);
        e.stamp = cyc;
        sb.push_back(e);
    endtask

    // R2: each item is compared at the falling edge after the capturing edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].stamp < cyc) begin
            item_t e;
            e = sb.pop_front();
            total++;
            if (res !== e.res || cout !== e.cout || lt !== e.lt || we !== e.we) begin
                bad++;
                $display("FAIL %s/R2 fn=%b a=%h b=%h got res=%h c=%b lt=%b we=%b exp res=%h c=%b lt=%b we=%b",
                         req_of(e.fn), e.fn, e.a, e.b, res, cout, lt, we, e.res, e.cout, e.lt, e.we);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] corner [6];
        corner[0] = 8'h00; corner[1] = 8'h01; corner[2] = 8'h7F;
        corner[3] = 8'h80; corner[4] = 8'hFF; corner[5] = 8'h5A;
        sri = 8'hC3; snd = 8'h3C; func = 4'd1;
        repeat (3) @(negedge clk);
        // R1: reset holds all outputs low despite active inputs
        total++;
        if (res !== 8'h00 || cout !== 0 || lt !== 0 || we !== 0) begin
            bad++;
            $display("FAIL R1 got res=%h c=%b lt=%b we=%b exp all zero", res, cout, lt, we);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int f = 0; f < 16; f++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    drive(4'(f), corner[i], corner[j]);
        for (int k = 0; k < 400; k++)
            drive(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom));
        // R5: snd varies, result must track sri only
        for (int k = 0; k < 16; k++)
            drive(4'd8, 8'h96, 8'(k * 17));
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule